// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block holds a programmed alarm moment and watches the running BCD clock for it. Software writes two alarm words: one for time of day (seconds, minutes, hours) and one for the calendar (day of month, month). Every field has its own compare-enable bit, so an alarm can say "every minute at second 30" or "every 14 March at 09:00:00" by enabling only the fields that matter. The alarm never looks at the year.

The clock core supplies the current BCD fields together with a one-cycle pulse once per second. The comparison is evaluated only on that pulse. A match produces a one-cycle `alarm_event` pulse and sets a sticky `alarm_flag`. The flag stays set until `clr_req` is pulsed. The alarm words can be read back on two plain output buses, and unused bits read as zero. All pins are plain control and status levels. No data stream crosses the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `cal_alarm_match`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 loads the time alarm word. Seconds sit in bits 6:0 with their enable in bit 7, minutes in bits 14:8 with enable in bit 15, and hours in bits 21:16 with enable in bit 23. Every other bit reads back as 0 on `time_alarm_rd` from the cycle after the write.
- R2: A write with `wr_en`=1 and `wr_sel`=1 loads the calendar alarm word. Month sits in bits 20:16 with enable in bit 23, and day of month in bits 29:24 with enable in bit 31. There is no year field, so bits 15:0 and every other unnamed bit read back as 0 on `cal_alarm_rd`.
- R3: After reset both alarm words read zero, so all enables are off, and `alarm_flag` and `alarm_event` are low.
- R4: A match occurs when every enabled field equals the corresponding current BCD field. Disabled fields are ignored whatever their values.
- R5: With no enable bit set, no match ever occurs.
- R6: Matching is evaluated only in a cycle with `sec_tick`=1. A match raises `alarm_event` for exactly the following cycle, and outside such cycles `alarm_event` stays low.
- R7: `alarm_flag` rises together with `alarm_event` and holds until a cycle with `clr_req`=1. It reads 0 from the cycle after that clear.
- R8: When a match and `clr_req` occur in the same cycle, the match wins and `alarm_flag` stays or becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second from the clock core |
| cur_sec | input | 8 | Current BCD seconds |
| cur_min | input | 8 | Current BCD minutes |
| cur_hour | input | 8 | Current BCD hours |
| cur_date | input | 8 | Current BCD day of month |
| cur_month | input | 8 | Current BCD month |
| wr_en | input | 1 | Alarm word write strobe |
| wr_sel | input | 1 | 0 selects the time alarm word, 1 the calendar alarm word |
| wr_data | input | 32 | Word to write |
| clr_req | input | 1 | Clears the sticky alarm flag |
| time_alarm_rd | output | 32 | Time alarm word readback |
| cal_alarm_rd | output | 32 | Calendar alarm word readback |
| alarm_event | output | 1 | One-cycle pulse on a match |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The bench writes all-ones words and checks that reserved and year positions read zero. A design that kept those bits, or placed a field one bit off, shows a wrong readback value. It enables no fields while the stored values equal the clock and expects silence; a design that treats "nothing enabled" as a wildcard would fire every second. It holds a matching time without `sec_tick` to catch a comparator that fires every cycle, and it pulses clear in the same cycle as a match to catch a clear that wrongly wins. Randomly mixed enables and near-miss values then expose any field whose enable is miswired or whose compare ignores a bit.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD = 5;
  localparam int VAL_W  = 7;
  localparam int WORD_W = 32;

  // field order used inside the block
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;

  // significant BCD bits per field
  function automatic int fwidth(input int idx);
    case (idx)
      F_SEC:   return 7;
      F_MIN:   return 7;
      F_HOUR:  return 6;
      F_DATE:  return 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] fmask(input int idx);
    return VAL_W'((1 << fwidth(idx)) - 1);
  endfunction

  // byte lane of each field inside its alarm word
  function automatic int flane(input int idx);
    case (idx)
      F_SEC:   return 0;
      F_MIN:   return 1;
      F_HOUR:  return 2;
      F_DATE:  return 3;
      default: return 2;
    endcase
  endfunction

  // 0: time word, 1: calendar word
  function automatic logic fword(input int idx);
    return (idx == F_DATE || idx == F_MON);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_sel,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [NFIELD-1:0]              fld_en,
  output logic [NFIELD-1:0][VAL_W-1:0]   fld_val,
  output logic [WORD_W-1:0]              time_word,
  output logic [WORD_W-1:0]              cal_word
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int LO = 8 * flane(i);
    logic              en_q;
    logic [VAL_W-1:0]  val_q;
    logic              hit_word;
    assign hit_word = wr_en && (wr_sel == fword(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        val_q <= '0;
      end else if (hit_word) begin
        en_q  <= wr_data[LO+7];
        val_q <= wr_data[LO +: VAL_W] & fmask(i);
      end
    end
    assign fld_en[i]  = en_q;
    assign fld_val[i] = val_q;
  end

  // readback assembly, unused bits zero
  always_comb begin
    time_word = '0;
    cal_word  = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (fword(i)) begin
        cal_word[8*flane(i) +: VAL_W] = fld_val[i];
        cal_word[8*flane(i) + 7]      = fld_en[i];
      end else begin
        time_word[8*flane(i) +: VAL_W] = fld_val[i];
        time_word[8*flane(i) + 7]      = fld_en[i];
      end
    end
  end
endmodule

// File: rtl/field_cmp.sv
module field_cmp
  import cal_alarm_pkg::*;
(
  input  logic [NFIELD-1:0]             fld_en,
  input  logic [NFIELD-1:0][VAL_W-1:0]  fld_val,
  input  logic [NFIELD-1:0][7:0]        cur,
  output logic                          match
);
  logic [NFIELD-1:0] hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    logic [VAL_W-1:0] cur_m;
    logic             unused_top;
    assign cur_m      = cur[i][VAL_W-1:0] & fmask(i);
    assign unused_top = cur[i][7];
    assign hit[i]     = !fld_en[i] || (fld_val[i] == cur_m);
  end

  assign match = (|fld_en) && (&hit);
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic match,
  input  logic clr_req,
  output logic event_o,
  output logic flag_o
);
  logic fire;
  assign fire = sec_tick && match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      event_o <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      event_o <= fire;
      if (fire)         flag_o <= 1'b1;
      else if (clr_req) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_date,
  input  logic [7:0]        cur_month,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_req,
  output logic [WORD_W-1:0] time_alarm_rd,
  output logic [WORD_W-1:0] cal_alarm_rd,
  output logic              alarm_event,
  output logic              alarm_flag
);
  logic [NFIELD-1:0]             fld_en;
  logic [NFIELD-1:0][VAL_W-1:0]  fld_val;
  logic [NFIELD-1:0][7:0]        cur;
  logic                          match;

  always_comb begin
    cur[F_SEC]  = cur_sec;
    cur[F_MIN]  = cur_min;
    cur[F_HOUR] = cur_hour;
    cur[F_DATE] = cur_date;
    cur[F_MON]  = cur_month;
  end

  alarm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .fld_en    (fld_en),
    .fld_val   (fld_val),
    .time_word (time_alarm_rd),
    .cal_word  (cal_alarm_rd)
  );

  field_cmp u_cmp (
    .fld_en  (fld_en),
    .fld_val (fld_val),
    .cur     (cur),
    .match   (match)
  );

  alarm_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .match    (match),
    .clr_req  (clr_req),
    .event_o  (alarm_event),
    .flag_o   (alarm_flag)
  );
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        clr_req,
  input logic [31:0] time_alarm_rd,
  input logic [31:0] cal_alarm_rd,
  input logic        alarm_event,
  input logic        alarm_flag
);
  logic no_en;
  assign no_en = !time_alarm_rd[7] && !time_alarm_rd[15] && !time_alarm_rd[23]
              && !cal_alarm_rd[23] && !cal_alarm_rd[31];

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    time_alarm_rd[31:24] == 8'h0 && time_alarm_rd[22] == 1'b0);

  assert_no_year_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_alarm_rd[15:0] == 16'h0);

  assert_silent_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && no_en) |=> !alarm_event);

  assert_event_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick) |=> !alarm_event);

  assert_flag_with_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_event |-> alarm_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_req) |=> alarm_flag);

  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> alarm_event);
endmodule

bind cal_alarm_match cal_alarm_match_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sec_tick      (sec_tick),
  .clr_req       (clr_req),
  .time_alarm_rd (time_alarm_rd),
  .cal_alarm_rd  (cal_alarm_rd),
  .alarm_event   (alarm_event),
  .alarm_flag    (alarm_flag)
);

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, clr_req = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_alarm_rd, cal_alarm_rd;
  logic        alarm_event, alarm_flag;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_time = '0, m_cal = '0;
  logic        m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .clr_req(clr_req),
    .time_alarm_rd(time_alarm_rd), .cal_alarm_rd(cal_alarm_rd),
    .alarm_event(alarm_event), .alarm_flag(alarm_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected readback after a write, per the field layout of R1/R2
  function automatic logic [31:0] time_mask(input logic [31:0] d);
    return d & 32'h00BF_FFFF;
  endfunction
  function automatic logic [31:0] cal_mask(input logic [31:0] d);
    return d & 32'hBF9F_0000;
  endfunction

  function automatic logic exp_match(input logic [31:0] tw, input logic [31:0] cw,
                                     input logic [7:0] s, input logic [7:0] mi,
                                     input logic [7:0] h, input logic [7:0] d,
                                     input logic [7:0] mo);
    logic any, ok;
    any = tw[7] | tw[15] | tw[23] | cw[23] | cw[31];
    ok = 1'b1;
    if (tw[7]  && tw[6:0]   != s[6:0])  ok = 1'b0;
    if (tw[15] && tw[14:8]  != mi[6:0]) ok = 1'b0;
    if (tw[23] && tw[21:16] != h[5:0])  ok = 1'b0;
    if (cw[31] && cw[29:24] != d[5:0])  ok = 1'b0;
    if (cw[23] && cw[20:16] != mo[4:0]) ok = 1'b0;
    return any && ok;
  endfunction

  task automatic write_word(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) m_cal = cal_mask(d); else m_time = time_mask(d);
  endtask

  task automatic set_cur(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo);
    cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d; cur_month = mo;
  endtask

  // one tick cycle, optional clear in the same cycle; checks event and flag
  task automatic tick(input logic clr, input string req);
    logic m;
    m = exp_match(m_time, m_cal, cur_sec, cur_min, cur_hour, cur_date, cur_month);
    sec_tick = 1'b1; clr_req = clr;
    @(negedge clk);
    sec_tick = 1'b0; clr_req = 1'b0;
    m_flag = m ? 1'b1 : (clr ? 1'b0 : m_flag);
    check({req, " event"}, {31'b0, alarm_event}, {31'b0, m});
    check({req, " flag"},  {31'b0, alarm_flag},  {31'b0, m_flag});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    check("R3 time word", time_alarm_rd, 32'h0);
    check("R3 cal word", cal_alarm_rd, 32'h0);
    check("R3 flag", {31'b0, alarm_flag}, 32'h0);
    check("R3 event", {31'b0, alarm_event}, 32'h0);

    // R1, R2 layout and reserved bits
    write_word(1'b0, 32'hFFFF_FFFF);
    check("R1 time readback", time_alarm_rd, 32'h00BF_FFFF);
    write_word(1'b1, 32'hFFFF_FFFF);
    check("R2 cal readback (no year)", cal_alarm_rd, 32'hBF9F_0000);

    // R5: values equal current but nothing enabled
    write_word(1'b0, 32'h0012_3456 & 32'h007F_7F7F);
    write_word(1'b1, 32'h1503_0000);
    set_cur(8'h56, 8'h34, 8'h12, 8'h15, 8'h03);
    tick(1'b0, "R5 no enable");

    // R4: only seconds enabled, other fields mismatching
    write_word(1'b0, 32'h0000_00B0);
    set_cur(8'h30, 8'h59, 8'h23, 8'h31, 8'h12);
    tick(1'b0, "R4 seconds only");

    // R6: matching values held without tick, flag cleared first
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0; m_flag = 1'b0;
    check("R7 clear", {31'b0, alarm_flag}, 32'h0);
    repeat (4) @(negedge clk);
    check("R6 no tick event", {31'b0, alarm_event}, 32'h0);
    check("R6 no tick flag", {31'b0, alarm_flag}, 32'h0);

    // R4: full date + time match; date mismatch then match
    write_word(1'b0, 32'h0089_8A8B & 32'h00BF_FFFF);
    write_word(1'b1, 32'h9492_0000);
    set_cur(8'h0B, 8'h0A, 8'h09, 8'h13, 8'h12);
    tick(1'b0, "R4 date mismatch");
    set_cur(8'h0B, 8'h0A, 8'h09, 8'h14, 8'h12);
    tick(1'b0, "R4 full match");
    @(negedge clk);
    check("R6 single pulse", {31'b0, alarm_event}, 32'h0);
    check("R7 sticky", {31'b0, alarm_flag}, 32'h1);

    // R8: clear coinciding with a match
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0; m_flag = 1'b0;
    tick(1'b1, "R8 match beats clear");

    // random mix, R4 R5 R6 R7
    for (int it = 0; it < 400; it++) begin
      logic [31:0] tw, cw;
      logic [7:0]  s, mi, h, d, mo;
      tw = $urandom; cw = $urandom;
      if ($urandom_range(0, 3) == 0) write_word(1'b0, tw);
      if ($urandom_range(0, 3) == 0) write_word(1'b1, cw);
      s  = {1'b0, m_time[6:0]};
      mi = {1'b0, m_time[14:8]};
      h  = {2'b0, m_time[21:16]};
      d  = {2'b0, m_cal[29:24]};
      mo = {3'b0, m_cal[20:16]};
      if ($urandom_range(0, 2) == 0) s  = {1'b0, 7'($urandom)};
      if ($urandom_range(0, 2) == 0) mi = {1'b0, 7'($urandom)};
      if ($urandom_range(0, 4) == 0) h  = {2'b0, 6'($urandom)};
      if ($urandom_range(0, 4) == 0) d  = {2'b0, 6'($urandom)};
      if ($urandom_range(0, 4) == 0) mo = {3'b0, 5'($urandom)};
      set_cur(s, mi, h, d, mo);
      tick($urandom_range(0, 3) == 0, "R4 random");
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        check("R6 random idle", {31'b0, alarm_event}, 32'h0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule